// File: doc/BRIEF.md
# Embedded-Clock Frame Lock Supervisor

This block runs from a local reference clock and watches a stream of already-sampled serial bits, qualified by a valid strobe, from a link that sends 12-bit frames with an embedded clock. Each frame is a clock bit of 1, then ten payload bits with D0 first, then a clock bit of 0. Between frames this gives exactly one guaranteed low-to-high transition. After reset the supervisor hunts for the training word: six ones followed by six zeros. When it finds that word it takes the next valid bit as the start of a frame and pulls its active-low lock flag low.

While locked it assembles each frame and checks that the two clock bits are in place. It presents the 10-bit payload together with a one-cycle strobe. A recovered-clock level is high for the first half of every frame. The block counts frames whose clock bits are wrong, one after another; the fourth such frame in a row ends lock, so loss is reported within a few word times. A system can wire the lock flag straight back to the transmitter as its request for training words, so that resynchronisation happens without any other help.

The block also produces the output-enable controls for the payload bus, the recovered clock and the lock flag, based on a receiver-enable input. The lock flag follows an asymmetric rule. It floats only when the enable is dropped while the link is locked. If the link is unlocked when the enable is low, the flag stays driven, and it goes low on lock whatever the enable is.

Top module: `dslk_lock_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, lock_n is 1, word_vld is 0, word_out is 0, rclk is 0, data_oe and rclk_oe are 0, and lock_oe is 1.
- R2: In the search state, lock is gained on the clock edge that takes the last of twelve consecutive valid bits 111111000000 (first received on the left). From the next edge lock_n reads 0, and the next valid bit is bit 0 of a frame.
- R3: A cycle with rx_bit_vld low does not shift, count or check anything; the value on rx_bit is ignored.
- R4: While locked, a frame is 12 valid bits: bit 0 a clock bit, bits 1..10 the payload with D0 first, and bit 11 a clock bit. For an aligned frame, one cycle after its last bit word_vld is 1 for exactly one cycle, and word_out holds the payload with D0 in bit 0.
- R5: A frame is misaligned when its bit 0 is not 1 or its bit 11 is not 0. A misaligned frame gives no strobe. An aligned frame clears the count of misaligned frames in a row. The fourth misaligned frame in a row returns the block to search: lock_n reads 1 and word_out reads 0 one cycle after that frame's last bit.
- R6: In the search state word_vld stays 0 and word_out holds 0.
- R7: data_oe and rclk_oe are 1 exactly when rx_en, as sampled on the previous edge, was 1 and the block is locked.
- R8: lock_oe goes to 0 only when rx_en is sampled 1 and then 0 on consecutive edges while lock is held. It stays 0 while rx_en stays low and lock holds. Lock gained while rx_en is low leaves lock_oe at 1.
- R9: rclk is 1 while locked and fewer than 6 valid bits of the current frame have been taken; otherwise it is 0.
- R10: On loss of lock, lock_oe is 1 from the same edge on which lock_n rises, even if rx_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Sampled serial bit |
| rx_bit_vld | input | 1 | rx_bit holds a new bit this cycle |
| rx_en | input | 1 | Receiver enable |
| lock_n | output | 1 | Active-low lock flag |
| word_out | output | 10 | Recovered payload word |
| word_vld | output | 1 | One-cycle strobe per aligned frame |
| rclk | output | 1 | Recovered clock level |
| data_oe | output | 1 | Drive enable for the payload bus |
| rclk_oe | output | 1 | Drive enable for the recovered clock |
| lock_oe | output | 1 | Drive enable for the lock flag |

## Verification
The hardest state to reach from the ports is a floating lock flag that must return the moment lock is lost. Getting there needs lock, then the enable raised and dropped, then four bad frames in a row while the enable stays low. The bench reaches it by inserting one surplus bit into a locked stream, which shifts every later frame by one position. This makes each window start on a 0 clock bit, and the stream is also built so that no training word can appear by chance. A long random phase with gaps in the valid strobe, injected training words and enable toggles then runs against the behavioural model.

// File: rtl/dslk_pkg.sv
package dslk_pkg;

   typedef enum logic {
      ST_SEARCH = 1'b0,
      ST_LOCK   = 1'b1
   } lk_state_e;

   function automatic int frame_bits(input int payload_w);
      return payload_w + 2;
   endfunction

endpackage

// File: rtl/dslk_sync_detect.sv
module dslk_sync_detect #(
   parameter int FRAME_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_in,
   input  logic               bit_vld,
   output logic [FRAME_W-1:0] win_nx,
   output logic               sync_hit
);
   localparam int RUN_W = FRAME_W / 2;
   localparam logic [FRAME_W-1:0] TRAIN_PAT = {{RUN_W{1'b1}}, {(FRAME_W - RUN_W){1'b0}}};

   logic [FRAME_W-1:0] win_q;

   // oldest bit sits in the MSB, newest in bit 0
   always_comb begin
      win_nx = win_q;
      if (bit_vld) begin
         win_nx = {win_q[FRAME_W-2:0], bit_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else begin
         win_q <= win_nx;
      end
   end

   assign sync_hit = bit_vld && (win_nx == TRAIN_PAT);

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> $stable(win_q)); // R3

endmodule

// File: rtl/dslk_frame_track.sv
module dslk_frame_track
   import dslk_pkg::*;
#(
   parameter int DATA_W     = 10,
   parameter int FRAME_W    = 12,
   parameter int MISS_LIMIT = 4,
   parameter int CNT_W      = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_vld,
   input  logic               sync_hit,
   input  logic [FRAME_W-1:0] win_nx,
   output logic               locked,
   output logic               lock_nx,
   output logic [CNT_W-1:0]   pos_q,
   output logic [DATA_W-1:0]  word_q,
   output logic               vld_q
);
   localparam int MISS_W = $clog2(MISS_LIMIT + 1);
   localparam logic [CNT_W-1:0]  LAST_POS  = CNT_W'(FRAME_W - 1);
   localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

   lk_state_e           state_q, state_d;
   logic [CNT_W-1:0]    cnt_d;
   logic [MISS_W-1:0]   miss_q, miss_d;
   logic [DATA_W-1:0]   word_d, word_nx;
   logic                vld_d;
   logic                aligned;

   // payload D0 is the oldest payload bit in the window
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_word
      assign word_nx[gi] = win_nx[FRAME_W-2-gi];
   end

   assign aligned = win_nx[FRAME_W-1] & ~win_nx[0];

   always_comb begin
      state_d = state_q;
      cnt_d   = pos_q;
      miss_d  = miss_q;
      word_d  = word_q;
      vld_d   = 1'b0;
      unique case (state_q)
         ST_SEARCH: begin
            cnt_d  = '0;
            miss_d = '0;
            if (sync_hit) begin
               state_d = ST_LOCK;
            end
         end
         ST_LOCK: begin
            if (bit_vld) begin
               if (pos_q == LAST_POS) begin
                  cnt_d = '0;
                  if (aligned) begin
                     miss_d = '0;
                     vld_d  = 1'b1;
                     word_d = word_nx;
                  end else if (miss_q == MISS_LAST) begin
                     state_d = ST_SEARCH;
                     miss_d  = '0;
                     word_d  = '0;
                  end else begin
                     miss_d = miss_q + 1'b1;
                  end
               end else begin
                  cnt_d = pos_q + 1'b1;
               end
            end
         end
         default: state_d = ST_SEARCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_SEARCH;
         pos_q   <= '0;
         miss_q  <= '0;
         word_q  <= '0;
         vld_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         pos_q   <= cnt_d;
         miss_q  <= miss_d;
         word_q  <= word_d;
         vld_q   <= vld_d;
      end
   end

   assign locked  = (state_q == ST_LOCK);
   assign lock_nx = (state_d == ST_LOCK);

   AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      miss_q <= MISS_LAST); // R5
   AST_ACQUIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEARCH && sync_hit) |=> (state_q == ST_LOCK)); // R2
   AST_STROBE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> (state_q == ST_LOCK)); // R6
   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q); // R4
   AST_SEARCH_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEARCH) |-> (word_q == '0)); // R6

endmodule

// File: rtl/dslk_oe_ctrl.sv
module dslk_oe_ctrl #(
   parameter int FRAME_W = 12,
   parameter int CNT_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             locked,
   input  logic             lock_nx,
   input  logic [CNT_W-1:0] pos_q,
   output logic             data_oe,
   output logic             rclk_oe,
   output logic             lock_oe,
   output logic             rclk
);
   localparam logic [CNT_W-1:0] HALF_POS = CNT_W'(FRAME_W / 2);

   logic en_q;
   logic float_q;

   // the flag floats only if enable falls while lock is held,
   // and stops floating as soon as lock goes or enable returns
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         float_q <= 1'b0;
      end else begin
         en_q    <= rx_en;
         float_q <= ~rx_en & lock_nx & (float_q | en_q);
      end
   end

   assign data_oe = en_q & locked;
   assign rclk_oe = en_q & locked;
   assign lock_oe = en_q | ~float_q;
   assign rclk    = locked & (pos_q < HALF_POS);

   AST_FLOAT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_oe |-> locked); // R8
   AST_LOSS_DRIVES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> lock_oe); // R10

endmodule

// File: rtl/dslk_lock_ctrl.sv
module dslk_lock_ctrl
   import dslk_pkg::*;
#(
   parameter int DATA_W     = 10,
   parameter int MISS_LIMIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_bit,
   input  logic              rx_bit_vld,
   input  logic              rx_en,
   output logic              lock_n,
   output logic [DATA_W-1:0] word_out,
   output logic              word_vld,
   output logic              rclk,
   output logic              data_oe,
   output logic              rclk_oe,
   output logic              lock_oe
);
   localparam int FRAME_W = frame_bits(DATA_W);
   localparam int CNT_W   = $clog2(FRAME_W);

   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("DATA_W must be even and at least 2");
   end
   if (MISS_LIMIT < 1) begin : g_bad_limit
      $error("MISS_LIMIT must be at least 1");
   end

   logic [FRAME_W-1:0] win_nx;
   logic               sync_hit;
   logic               locked;
   logic               lock_nx;
   logic [CNT_W-1:0]   pos_q;

   dslk_sync_detect #(.FRAME_W(FRAME_W)) i_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_in   (rx_bit),
      .bit_vld  (rx_bit_vld),
      .win_nx   (win_nx),
      .sync_hit (sync_hit)
   );

   dslk_frame_track #(
      .DATA_W     (DATA_W),
      .FRAME_W    (FRAME_W),
      .MISS_LIMIT (MISS_LIMIT),
      .CNT_W      (CNT_W)
   ) i_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_vld  (rx_bit_vld),
      .sync_hit (sync_hit),
      .win_nx   (win_nx),
      .locked   (locked),
      .lock_nx  (lock_nx),
      .pos_q    (pos_q),
      .word_q   (word_out),
      .vld_q    (word_vld)
   );

   dslk_oe_ctrl #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_oe (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_en   (rx_en),
      .locked  (locked),
      .lock_nx (lock_nx),
      .pos_q   (pos_q),
      .data_oe (data_oe),
      .rclk_oe (rclk_oe),
      .lock_oe (lock_oe),
      .rclk    (rclk)
   );

   assign lock_n = ~locked;

   AST_LOCK_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      lock_n |-> !word_vld); // R5

endmodule

// File: tb/test_dslk_lock_ctrl.sv
module test_dslk_lock_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_bit = 1'b0;
   logic       rx_bit_vld = 1'b0;
   logic       rx_en = 1'b0;
   logic       lock_n;
   logic [9:0] word_out;
   logic       word_vld;
   logic       rclk;
   logic       data_oe;
   logic       rclk_oe;
   logic       lock_oe;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit compare_on = 1'b0;

   always #10 clk = ~clk;

   dslk_lock_ctrl i_dslk_lock_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
      .rx_en(rx_en), .lock_n(lock_n), .word_out(word_out), .word_vld(word_vld),
      .rclk(rclk), .data_oe(data_oe), .rclk_oe(rclk_oe), .lock_oe(lock_oe)
   );

   // ---------------- behavioural reference model ----------------
   int hist[$];
   int m_lock = 0, m_cnt = 0, m_miss = 0, m_vld = 0, m_word = 0;
   int m_en = 0, m_float = 0;

   function automatic bit hist_is_train();
      for (int k = 0; k < 12; k++) begin
         if (hist[k] != ((k < 6) ? 1 : 0)) return 1'b0;
      end
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         for (int k = 0; k < 12; k++) hist.push_back(0);
         m_lock = 0; m_cnt = 0; m_miss = 0; m_vld = 0; m_word = 0;
         m_en = 0; m_float = 0;
      end else begin
         m_vld = 0;
         if (rx_bit_vld) begin
            hist.push_back(int'(rx_bit));
            void'(hist.pop_front());
            if (m_lock == 0) begin
               if (hist_is_train()) begin
                  m_lock = 1; m_cnt = 0; m_miss = 0;
               end
            end else begin
               m_cnt++;
               if (m_cnt == 12) begin
                  m_cnt = 0;
                  if (hist[0] == 1 && hist[11] == 0) begin
                     m_miss = 0; m_vld = 1; m_word = 0;
                     for (int k = 0; k < 10; k++) m_word |= hist[1+k] << k;
                  end else begin
                     m_miss++;
                     if (m_miss == 4) begin
                        m_lock = 0; m_miss = 0; m_word = 0;
                     end
                  end
               end
            end
         end
         if (!rx_en) begin
            if (m_lock == 0) m_float = 0;
            else if (m_float == 1 || m_en == 1) m_float = 1;
            else m_float = 0;
         end else begin
            m_float = 0;
         end
         m_en = int'(rx_en);
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input int act, input int exp, input string req, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(int'(lock_n), (m_lock != 0) ? 0 : 1, "R2/R5", "lock_n");
      chk(int'(word_out), m_word, "R4/R6", "word_out");
      chk(int'(word_vld), m_vld, "R4", "word_vld");
      chk(int'(rclk), (m_lock != 0 && m_cnt < 6) ? 1 : 0, "R9", "rclk");
      chk(int'(data_oe), (m_en != 0 && m_lock != 0) ? 1 : 0, "R7", "data_oe");
      chk(int'(rclk_oe), (m_en != 0 && m_lock != 0) ? 1 : 0, "R7", "rclk_oe");
      chk(int'(lock_oe), (m_en != 0 || m_float == 0) ? 1 : 0, "R8/R10", "lock_oe");
   endtask

   task automatic drive(input bit b, input bit v);
      @(negedge clk);
      if (compare_on) compare_all();
      rx_bit = b;
      rx_bit_vld = v;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) drive(1'b0, 1'b0);
   endtask

   task automatic send_frame(input int w, input bit sb, input bit eb);
      drive(sb, 1'b1);
      for (int k = 0; k < 10; k++) drive(bit'((w >> k) & 1), 1'b1);
      drive(eb, 1'b1);
   endtask

   task automatic send_train();
      for (int k = 0; k < 12; k++) drive(k < 6, 1'b1);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk(int'(lock_n), 1, "R1", "lock_n in reset");
      chk(int'(lock_oe), 1, "R1", "lock_oe in reset");
      chk(int'(data_oe), 0, "R1", "data_oe in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare_on = 1'b1;
      chk(int'(word_vld), 0, "R1", "word_vld after reset");
      chk(int'(word_out), 0, "R1", "word_out after reset");
      chk(int'(rclk), 0, "R1", "rclk after reset");

      rx_en = 1'b1;
      // R6: alternating bits never form the training word
      for (int k = 0; k < 30; k++) drive(k[0], 1'b1);
      idle(1);
      chk(int'(lock_n), 1, "R6", "no lock on alternating bits");

      // R3: training word with invalid garbage between its bits
      for (int k = 0; k < 12; k++) begin
         drive(k < 6, 1'b1);
         drive(k >= 6, 1'b0);
      end
      idle(1);
      chk(int'(lock_n), 0, "R2", "lock after gapped training word");
      chk(int'(rclk), 1, "R9", "rclk high at frame start");

      send_frame(10'h2A5, 1'b1, 1'b0);
      idle(1);
      chk(int'(word_vld), 1, "R4", "strobe for 0x2A5");
      chk(int'(word_out), 'h2A5, "R4", "word 0x2A5");
      idle(1);
      chk(int'(word_vld), 0, "R4", "strobe is one cycle");

      // R3: garbage with valid low in the middle of a frame
      drive(1'b1, 1'b1);
      for (int k = 0; k < 5; k++) drive(1'b1, 1'b1);
      for (int k = 0; k < 7; k++) drive(k[0], 1'b0);
      idle(1);
      chk(int'(rclk), 0, "R3", "position frozen while valid low");
      for (int k = 5; k < 10; k++) drive(1'b0, 1'b1);
      drive(1'b0, 1'b1);
      idle(1);
      chk(int'(word_out), 'h01F, "R3", "frame intact across gap");

      send_frame(10'h3FF, 1'b1, 1'b0);
      send_frame(10'h000, 1'b1, 1'b0);
      idle(1);
      chk(int'(word_out), 0, "R4", "word 0x000");

      // R5: three bad frames then a good one keeps lock
      for (int k = 0; k < 3; k++) send_frame(10'h155, 1'b1, 1'b1);
      idle(1);
      chk(int'(word_vld), 0, "R5", "no strobe for bad frame");
      send_frame(10'h0AA, 1'b1, 1'b0);
      idle(1);
      chk(int'(lock_n), 0, "R5", "lock kept after three bad frames");
      chk(int'(word_out), 'h0AA, "R5", "good frame clears run");

      // R5: four bad frames in a row lose lock
      for (int k = 0; k < 3; k++) send_frame(10'h155, 1'b0, 1'b0);
      idle(1);
      chk(int'(lock_n), 0, "R5", "still locked after third bad frame");
      send_frame(10'h155, 1'b0, 1'b0);
      idle(1);
      chk(int'(lock_n), 1, "R5", "lock lost on fourth bad frame");
      chk(int'(word_out), 0, "R5", "word cleared on loss");

      // R8: lock gained with enable low keeps the flag driven
      rx_en = 1'b0;
      idle(2);
      send_train();
      idle(1);
      chk(int'(lock_n), 0, "R8", "lock with enable low");
      chk(int'(lock_oe), 1, "R8", "flag driven after lock with enable low");
      chk(int'(data_oe), 0, "R7", "data off with enable low");
      rx_en = 1'b1;
      idle(2);
      chk(int'(data_oe), 1, "R7", "data on with enable high");
      rx_en = 1'b0;
      idle(2);
      chk(int'(lock_oe), 0, "R8", "flag floats when enable falls in lock");
      chk(int'(rclk_oe), 0, "R7", "rclk off when enable falls");

      // R10: one surplus bit misaligns every later frame
      drive(1'b0, 1'b1);
      for (int k = 0; k < 4; k++) send_frame(10'h155, 1'b1, 1'b0);
      idle(1);
      chk(int'(lock_n), 1, "R10", "lock lost after slip");
      chk(int'(lock_oe), 1, "R10", "flag driven again on loss");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 299) == 0) rx_en = ~rx_en;
         if ($urandom_range(0, 399) == 0) send_train();
         else if ($urandom_range(0, 5) == 0)
            send_frame(int'($urandom_range(0, 1023)), 1'b1, $urandom_range(0, 7) == 0);
         else drive(bit'($urandom_range(0, 1)), $urandom_range(0, 3) != 0);
      end
      idle(2);
      report();
   end
endmodule